// File: doc/BRIEF.md
# Serial NVM Slave Front End

This block is the bus-facing controller of a 256-byte non-volatile store that sits on a two-wire serial bus as a slave. The array is held in a block-RAM style register array. The block oversamples the clock and data lines with the system clock. It finds START and STOP conditions and decodes the slave address byte. It then serves five transfer types: byte write, page write, current-address read, random read and sequential read.

Written bytes are not stored in the array at once. They collect in a page buffer, and a STOP commits them during a timed internal write cycle. While that cycle runs, the block refuses its own address, so a host can poll with address bytes until the device acknowledges. A write-protect input lets a write run through the word address but refuses the first data byte. A reset-inhibit input aborts any bus activity at once, but it never cuts short a write cycle that has already begun.

Top module: `serial_nvm_slave`

## Requirements
- R1: The slave acknowledges an address byte only when bits 7..4 equal `dev_type` and bits 3..1 are zero. Bit 0 selects the direction: 1 is read, 0 is write. Any other address byte gets no acknowledge.
- R2: START is a falling data line while the clock is high, and STOP is a rising data line while the clock is high. The data line is released after reset, and the slave changes its pull only while the clock is low.
- R3: In a write, the byte after the address byte is the word address. A data byte that follows it is acknowledged and becomes readable once the write cycle ends.
- R4: During a page write, only address bits 3..0 step after each data byte, and bits 7..4 stay fixed. A seventeenth byte therefore overwrites the first byte of the transfer.
- R5: A STOP after at least one acknowledged data byte starts a write cycle of `WC_CYCLES` clocks. For that whole time, address bytes get no acknowledge.
- R6: A STOP after only the address byte, or after only the word address, starts no write cycle. A word address sent this way still sets the address counter.
- R7: A current-address read returns the byte at the last accessed read address plus one. The counter wraps from 255 to 0.
- R8: A random read is a write of the word address, then a repeated START and a read address byte. It returns the byte at that word address.
- R9: In a sequential read, each master acknowledge advances all eight address bits, so the read crosses page boundaries.
- R10: If the master does not acknowledge a read byte, the slave releases the data line and stays off the bus until the next START or STOP.
- R11: With `wp` high, the slave acknowledges the address byte and the word address. It refuses the first data byte, and the array is not changed.
- R12: While `inhibit` is high, the slave acknowledges nothing and drops any transfer in progress. A write cycle that has already started still completes.
- R13: Read data is sent most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired level) |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |
| wp | input | 1 | Write protect, active high |
| inhibit | input | 1 | Reset inhibit, active high |
| dev_type | input | 4 | Device-type field matched against address bits 7..4 |

## Verification
The hardest condition to reach from the ports is the window in which a write cycle is still running while the host is already back on the bus. The bench reaches it by issuing an address poll right after the committing STOP. It checks that this poll is refused and that the next poll, which falls past the cycle length, is accepted. The bench also raises the inhibit line a few clocks after such a STOP and then reads the data back, which shows that the running cycle was not cut short. Page wrap is reached by writing twenty bytes from an address in the middle of a page. A sequential read that runs over the page boundary then checks every location.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } bus_state_t;

  typedef enum logic [1:0] {
    BK_DEV,
    BK_WORD,
    BK_DATA
  } byte_kind_t;

  localparam int unsigned BYTE_BITS = 8;
endpackage

// File: rtl/nvm_bus_sync.sv
module nvm_bus_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] meta;
  logic [LINES-1:0] now_v;
  logic [LINES-1:0] old_v;

  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        meta[g]  <= 1'b1;
        now_v[g] <= 1'b1;
        old_v[g] <= 1'b1;
      end else begin
        meta[g]  <= raw[g];
        now_v[g] <= meta[g];
        old_v[g] <= now_v[g];
      end
    end
  end

  assign scl_s    = now_v[0];
  assign sda_s    = now_v[1];
  assign scl_rise = now_v[0] & ~old_v[0];
  assign scl_fall = ~now_v[0] & old_v[0];
  assign start_ev = now_v[0] & old_v[0] & old_v[1] & ~now_v[1];
  assign stop_ev  = now_v[0] & old_v[0] & ~old_v[1] & now_v[1];
endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int WC_CYCLES = 500
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bw_en,
  input  logic [PAGE_W-1:0]        bw_idx,
  input  logic [7:0]               bw_data,
  input  logic                     buf_clr,
  input  logic                     commit_go,
  input  logic [ADDR_W-PAGE_W-1:0] commit_base,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_q,
  output logic                     busy
);
  localparam int NPG   = 1 << PAGE_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TW    = $clog2(WC_CYCLES + 1);
  localparam logic [TW-1:0] NPG_T   = TW'(NPG);
  localparam logic [TW-1:0] LAST_T  = TW'(WC_CYCLES - 1);

  logic [7:0] mem  [DEPTH];
  logic [7:0] pbuf [NPG];
  logic [NPG-1:0] vld;
  logic [TW-1:0] tmr;
  logic [ADDR_W-PAGE_W-1:0] base;
  logic [PAGE_W-1:0] walk;
  logic wr_now;

  assign walk   = tmr[PAGE_W-1:0];
  assign wr_now = busy && (tmr < NPG_T) && vld[walk];

  // page buffer: plain storage, no reset
  always_ff @(posedge clk) begin
    if (bw_en) pbuf[bw_idx] <= bw_data;
  end

  // array: one write port for the commit walker, one registered read port
  always_ff @(posedge clk) begin
    if (wr_now) mem[{base, walk}] <= pbuf[walk];
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      tmr  <= '0;
      vld  <= '0;
      base <= '0;
    end else if (commit_go && !busy) begin
      busy <= 1'b1;
      tmr  <= '0;
      base <= commit_base;
    end else if (busy) begin
      if (tmr == LAST_T) begin
        busy <= 1'b0;
        vld  <= '0;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end else if (buf_clr) begin
      vld <= '0;
    end else if (bw_en) begin
      vld[bw_idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/nvm_bus_ctrl.sv
module nvm_bus_ctrl
  import nvm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sda_s,
  input  logic                     scl_rise,
  input  logic                     scl_fall,
  input  logic                     start_ev,
  input  logic                     stop_ev,
  input  logic [3:0]               dev_type,
  input  logic                     wp,
  input  logic                     inhibit,
  input  logic                     busy,
  input  logic [7:0]               rd_q,
  output logic                     sda_pull,
  output logic                     bw_en,
  output logic [PAGE_W-1:0]        bw_idx,
  output logic [7:0]               bw_data,
  output logic                     buf_clr,
  output logic                     commit_go,
  output logic [ADDR_W-PAGE_W-1:0] commit_base,
  output logic [ADDR_W-1:0]        rd_addr
);
  bus_state_t  st;
  byte_kind_t  kind;
  logic [3:0]  bit_cnt;
  logic [BYTE_BITS-1:0] sh;
  logic [ADDR_W-1:0] addr_cnt;
  logic is_read;
  logic pending;
  logic mack;

  logic bus_ok, byte_done, dev_ok, data_byte, wp_drop;

  assign bus_ok    = !inhibit && !stop_ev && !start_ev;
  assign byte_done = (st == ST_RX) && scl_fall && (bit_cnt == 4'd8);
  assign dev_ok    = (sh[7:4] == dev_type) && (sh[3:1] == 3'b000) && !busy;
  assign data_byte = bus_ok && byte_done && (kind == BK_DATA);
  assign bw_en     = data_byte && !wp;
  assign wp_drop   = data_byte && wp;
  assign bw_idx    = addr_cnt[PAGE_W-1:0];
  assign bw_data   = sh;
  assign commit_go = stop_ev && pending && !inhibit;
  assign commit_base = addr_cnt[ADDR_W-1:PAGE_W];
  assign buf_clr   = inhibit | start_ev | stop_ev | wp_drop;
  assign rd_addr   = addr_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      kind     <= BK_DEV;
      bit_cnt  <= '0;
      sh       <= '0;
      addr_cnt <= '0;
      is_read  <= 1'b0;
      pending  <= 1'b0;
      mack     <= 1'b0;
      sda_pull <= 1'b0;
    end else if (inhibit) begin
      st       <= ST_IDLE;
      sda_pull <= 1'b0;
      pending  <= 1'b0;
    end else if (stop_ev) begin
      st       <= ST_IDLE;
      sda_pull <= 1'b0;
      pending  <= 1'b0;
    end else if (start_ev) begin
      st       <= ST_RX;
      kind     <= BK_DEV;
      bit_cnt  <= '0;
      sda_pull <= 1'b0;
      pending  <= 1'b0;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise) begin
            sh      <= {sh[BYTE_BITS-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_done) begin
            unique case (kind)
              BK_DEV: begin
                if (dev_ok) begin
                  sda_pull <= 1'b1;
                  is_read  <= sh[0];
                  st       <= ST_ACK;
                end else begin
                  st <= ST_WAIT;
                end
              end
              BK_WORD: begin
                sda_pull <= 1'b1;
                addr_cnt <= sh[ADDR_W-1:0];
                st       <= ST_ACK;
              end
              default: begin
                if (wp) begin
                  pending <= 1'b0;
                  st      <= ST_WAIT;
                end else begin
                  sda_pull <= 1'b1;
                  pending  <= 1'b1;
                  addr_cnt <= {addr_cnt[ADDR_W-1:PAGE_W], addr_cnt[PAGE_W-1:0] + 1'b1};
                  st       <= ST_ACK;
                end
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (kind == BK_DEV && is_read) begin
              sh       <= rd_q;
              sda_pull <= ~rd_q[7];
              addr_cnt <= addr_cnt + 1'b1;
              st       <= ST_TX;
            end else begin
              sda_pull <= 1'b0;
              kind     <= (kind == BK_DEV) ? BK_WORD : BK_DATA;
              st       <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              sda_pull <= 1'b0;
              st       <= ST_MACK;
            end else begin
              sh       <= {sh[BYTE_BITS-2:0], 1'b0};
              sda_pull <= ~sh[BYTE_BITS-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            bit_cnt <= '0;
            if (mack) begin
              sh       <= rd_q;
              sda_pull <= ~rd_q[7];
              addr_cnt <= addr_cnt + 1'b1;
              st       <= ST_TX;
            end else begin
              sda_pull <= 1'b0;
              st       <= ST_WAIT;
            end
          end
        end
        default: begin
          sda_pull <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/serial_nvm_slave.sv
module serial_nvm_slave #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int WC_CYCLES = 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  input  logic       wp,
  input  logic       inhibit,
  input  logic [3:0] dev_type
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic bw_en, buf_clr, commit_go, busy;
  logic [PAGE_W-1:0] bw_idx;
  logic [7:0] bw_data, rd_q;
  logic [ADDR_W-PAGE_W-1:0] commit_base;
  logic [ADDR_W-1:0] rd_addr;

  nvm_bus_sync u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  nvm_bus_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .dev_type(dev_type), .wp(wp),
    .inhibit(inhibit), .busy(busy), .rd_q(rd_q), .sda_pull(sda_pull),
    .bw_en(bw_en), .bw_idx(bw_idx), .bw_data(bw_data), .buf_clr(buf_clr),
    .commit_go(commit_go), .commit_base(commit_base), .rd_addr(rd_addr)
  );

  nvm_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WC_CYCLES(WC_CYCLES)) u_store (
    .clk(clk), .rst(rst), .bw_en(bw_en), .bw_idx(bw_idx), .bw_data(bw_data),
    .buf_clr(buf_clr), .commit_go(commit_go), .commit_base(commit_base),
    .rd_addr(rd_addr), .rd_q(rd_q), .busy(busy)
  );
endmodule

// File: rtl/serial_nvm_slave_chk.sv
module serial_nvm_slave_chk #(
  parameter int WC_CYCLES = 500
) (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic sda_pull,
  input logic inhibit,
  input logic busy,
  input logic commit_go,
  input logic bw_en
);
  int unsigned busy_len;
  logic got_data;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_len <= 0;
    else              busy_len <= busy_len + 1;
  end

  always_ff @(posedge clk) begin
    if (rst)           got_data <= 1'b0;
    else if (bw_en)    got_data <= 1'b1;
    else if (busy)     got_data <= 1'b0;
  end

  // R2: the slave moves its pull only while the synchronized clock is low
  p_pull_scl_low_r2: assert property (@(posedge clk) disable iff (rst)
    ((sda_pull != $past(sda_pull)) && !$past(inhibit)) |-> !$past(scl_s));

  // R12: inhibit releases the data line on the next clock
  p_inhibit_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> !sda_pull);

  // R5: a write cycle lasts exactly WC_CYCLES clocks
  p_cycle_len_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_len == WC_CYCLES));

  // R5: no commit request arrives while a cycle is running
  p_commit_idle_r5: assert property (@(posedge clk) disable iff (rst)
    commit_go |-> !busy);

  // R6: a commit needs at least one accepted data byte
  p_commit_data_r6: assert property (@(posedge clk) disable iff (rst)
    commit_go |-> got_data);
endmodule

bind serial_nvm_slave serial_nvm_slave_chk #(.WC_CYCLES(WC_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_pull(sda_pull), .inhibit(inhibit),
  .busy(busy), .commit_go(commit_go), .bw_en(bw_en)
);

// File: tb/sim_serial_nvm_slave.sv
module sim_serial_nvm_slave;
  localparam int Q  = 10;
  localparam int WC = 600;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0, inhibit = 1'b0;
  logic [3:0] dev_type = 4'hA;
  logic sda_pull;
  wire  sda_line = sda_m & ~sda_pull;

  serial_nvm_slave #(.ADDR_W(8), .PAGE_W(4), .WC_CYCLES(WC)) u0 (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .sda_pull(sda_pull),
    .wp(wp), .inhibit(inhibit), .dev_type(dev_type)
  );

  int n_chk = 0, n_bad = 0, edge_bad = 0;
  logic [7:0] model [256];
  logic pull_q = 1'b0, inh_q = 1'b0;

  // R2 monitor: pull may only move while the bus clock is low
  always @(negedge clk) begin
    if (!rst && !inhibit && !inh_q && (sda_pull !== pull_q) && scl_m) edge_bad++;
    pull_q = sda_pull;
    inh_q  = inhibit;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q); tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); ack = ~sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl_m = 1'b1; tick(Q); b = {b[6:0], sda_line}; tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = ~mack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q); sda_m = 1'b1;
  endtask

  task automatic wait_ready(output int polls);
    logic a;
    polls = 0;
    do begin
      bus_start(); put_byte(8'hA0, a); bus_stop(); polls++;
    end while (!a && polls < 40);
  endtask

  task automatic write_run(input string req, input logic [7:0] addr, input int n, input logic [7:0] seed);
    logic a;
    logic [7:0] d;
    logic [7:0] loc;
    bus_start();
    put_byte(8'hA0, a); chk({req, " address ack"}, a, 1);
    put_byte(addr, a);  chk({req, " word address ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(k * 37);
      loc = {addr[7:4], addr[3:0] + 4'(k)};
      put_byte(d, a); chk({req, " data ack"}, a, 1);
      model[loc] = d;
    end
    bus_stop();
  endtask

  task automatic read_run(input string req, input bit set_addr, input logic [7:0] addr, input int n);
    logic a;
    logic [7:0] b;
    if (set_addr) begin
      bus_start(); put_byte(8'hA0, a); put_byte(addr, a);
    end
    bus_start();
    put_byte(8'hA1, a); chk({req, " read address ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      get_byte(k < n - 1, b);
      chk({req, " R13 data"}, b, model[8'(addr + 8'(k))]);
    end
    bus_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    int polls;
    tick(5);
    rst = 1'b0;
    tick(3);
    chk("R2 reset release", sda_pull, 0);

    // R1: sweep of every device-type nibble against dev_type = 1010
    for (int n = 0; n < 16; n++) begin
      bus_start(); put_byte({4'(n), 4'b0000}, a); bus_stop();
      chk("R1 device type sweep", a, (n == 10) ? 1 : 0);
    end
    bus_start(); put_byte(8'hA2, a); bus_stop(); chk("R1 nonzero low bits", a, 0);
    dev_type = 4'h3;
    bus_start(); put_byte(8'h30, a); bus_stop(); chk("R1 moved device type", a, 1);
    bus_start(); put_byte(8'hA0, a); bus_stop(); chk("R1 old device type", a, 0);
    dev_type = 4'hA;

    // R3 and R5: byte write, then polling during the cycle
    write_run("R3", 8'h00, 1, 8'h3C);
    bus_start(); put_byte(8'hA0, a); bus_stop(); chk("R5 poll during cycle", a, 0);
    wait_ready(polls); chk("R5 polls until ready", polls, 1);
    read_run("R8 random", 1'b1, 8'h00, 1);

    write_run("R3", 8'h30, 1, 8'h99); wait_ready(polls);
    write_run("R3", 8'h10, 1, 8'hA7); wait_ready(polls);
    write_run("R3", 8'h40, 1, 8'h11); wait_ready(polls);
    write_run("R3", 8'h50, 1, 8'h22); wait_ready(polls);

    // R4: twenty bytes from 0x25 wrap inside 0x20..0x2F
    write_run("R4", 8'h25, 20, 8'h01); wait_ready(polls);
    // R9: sequential read over the page boundary into 0x30
    read_run("R4 R9 sequential", 1'b1, 8'h20, 17);

    // R7: current-address read continues after the last read byte
    read_run("R7 current", 1'b1, 8'h25, 1);
    read_run("R7 current next", 1'b0, 8'h26, 1);
    read_run("R7 wrap setup", 1'b1, 8'hFF, 1);
    read_run("R7 wrap to zero", 1'b0, 8'h00, 1);

    // R10: after a master NACK the slave stays off the bus
    bus_start(); put_byte(8'hA0, a); put_byte(8'h10, a);
    bus_start(); put_byte(8'hA1, a);
    get_byte(1'b0, b); chk("R10 byte before nack", b, model[8'h10]);
    get_byte(1'b0, b); chk("R10 released after nack", b, 8'hFF);
    bus_stop();

    // R6: STOP after address only, and after word address only
    bus_start(); put_byte(8'hA0, a); bus_stop();
    bus_start(); put_byte(8'hA0, a); bus_stop(); chk("R6 no cycle after address", a, 1);
    bus_start(); put_byte(8'hA0, a); put_byte(8'h40, a); bus_stop();
    bus_start(); put_byte(8'hA0, a); bus_stop(); chk("R6 no cycle after word address", a, 1);
    read_run("R6 counter loaded", 1'b0, 8'h40, 1);

    // R11: write protect refuses the first data byte
    wp = 1'b1;
    bus_start();
    put_byte(8'hA0, a); chk("R11 address ack", a, 1);
    put_byte(8'h40, a); chk("R11 word address ack", a, 1);
    put_byte(8'hEE, a); chk("R11 data refused", a, 0);
    bus_stop();
    wp = 1'b0;
    bus_start(); put_byte(8'hA0, a); bus_stop(); chk("R11 no cycle", a, 1);
    read_run("R11 unchanged", 1'b1, 8'h40, 1);

    // R12: inhibit aborts a transfer and blocks acknowledges
    bus_start(); put_byte(8'hA0, a); put_byte(8'h50, a);
    inhibit = 1'b1;
    put_byte(8'h77, a); chk("R12 data refused", a, 0);
    bus_stop();
    bus_start(); put_byte(8'hA0, a); bus_stop(); chk("R12 address refused", a, 0);
    inhibit = 1'b0;
    bus_start(); put_byte(8'hA0, a); bus_stop(); chk("R12 no cycle after abort", a, 1);
    read_run("R12 unchanged", 1'b1, 8'h50, 1);

    // R12: a running cycle survives inhibit
    write_run("R12", 8'h60, 1, 8'h33);
    tick(10); inhibit = 1'b1; tick(800); inhibit = 1'b0; tick(10);
    read_run("R12 cycle completed", 1'b1, 8'h60, 1);

    chk("R2 pull moved only with clock low", edge_bad, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule